// File: doc/BRIEF.md
# Bitstream header clock ratio detector

This block sits beside the path that carries a configuration image into a device. It watches the first words of the image as they arrive, one 32-bit word per accepted beat. From two fixed places in the header it takes two properties of the image: whether it is encrypted and whether it is compressed. From those two flags and the configured bus width it computes the 2-bit clock-to-data ratio code that the configuration interface needs. The ratio comes from the image itself, so no constant has to be programmed for each image.

A start-of-image pulse clears the word count, the flags and the code. The first accepted beat after the pulse is word 0; if the pulse comes together with a valid beat, that beat is word 0. When word 229 is accepted, a one-cycle ratio-valid strobe is raised and the code is held until the next start. If the image ends before word 229 is seen, an error flag is raised instead. The block only observes the stream. It does not change, decrypt, decompress or forward the data.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, `is_encrypted`, `is_compressed`, `ratio_valid` and `short_err` are 0 and `ratio_code` is 0.
- R2: `is_encrypted` becomes 1 in the cycle after word index 69 is accepted if bits [3:2] of that word are nonzero. It becomes 0 if both bits are zero.
- R3: `is_compressed` becomes 1 in the cycle after word index 229 is accepted if bit 1 of that word is 0. It becomes 0 if that bit is 1.
- R4: An image that is neither encrypted nor compressed gets `ratio_code` 0 (x1) for either value of `wide_mode`.
- R5: Ratio encoding is 0=x1, 1=x2, 2=x4, 3=x8. A compressed image gets 2 with `wide_mode`=0 (16-bit) and 3 with `wide_mode`=1 (32-bit). An image that is encrypted but not compressed gets 1 in 16-bit mode and 2 in 32-bit mode.
- R6: `ratio_valid` is high for exactly one cycle, the cycle after word 229 is accepted. This happens once per image.
- R7: If a beat flagged `word_last` is accepted while its index is below 229, `short_err` rises in the next cycle and stays high until the next start. An image whose last word is word 229 raises `ratio_valid` and no error. `ratio_valid` and `short_err` are never high together.
- R8: `img_start` clears the flags, the code and `short_err` in the next cycle and restarts the count. A valid beat in the same cycle as `img_start` is word 0.
- R9: Beats with `word_valid` low are not counted and their data is ignored.
- R10: After word 229, later words (including a later `word_last`) leave the flags and code unchanged and raise neither strobe, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_start | input | 1 | Start of a new image; clears state |
| word_valid | input | 1 | `word_data` holds a word this cycle |
| word_data | input | 32 | Image word |
| word_last | input | 1 | Marks the final word of the image (qualified by `word_valid`) |
| wide_mode | input | 1 | 1 = 32-bit configuration bus, 0 = 16-bit |
| is_encrypted | output | 1 | Encrypted flag of the current image |
| is_compressed | output | 1 | Compressed flag of the current image |
| ratio_code | output | 2 | Clock-to-data ratio code |
| ratio_valid | output | 1 | One-cycle strobe when the code is produced |
| short_err | output | 1 | Image ended before the header was complete |

## Verification
Completion of the header and end of image can fall in the same beat: an image of exactly 230 words carries `word_last` on word 229. The bench sends that image and expects a single ratio-valid result with the correct code and no error. It also sends a 229-word image, whose end one beat earlier must give the error alone. The scoreboard monitor fails the run if both strobes are ever high in the same cycle, if a strobe comes with no expected item queued, or if items are left in the queue at the end.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_ENC_IDX = 69;
  localparam int unsigned DEF_ENC_LO  = 2;
  localparam int unsigned DEF_ENC_HI  = 3;
  localparam int unsigned DEF_CMP_IDX = 229;
  localparam int unsigned DEF_CMP_BIT = 1;

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int unsigned LAST_IDX = 229,
  parameter int unsigned IDX_W    = $clog2(LAST_IDX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             img_start,
  input  logic             word_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             accept
);

  logic [IDX_W-1:0] cnt_q;

  // A start in the same beat makes this beat word 0
  assign cur_idx = img_start ? '0 : cnt_q;
  assign accept  = word_valid && (cur_idx <= IDX_W'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= cur_idx + 1'b1;
    end else if (img_start) begin
      cnt_q <= '0;
    end
  end

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !img_start) |=> $stable(cnt_q));

endmodule

// File: rtl/hdr_ratio_encode.sv
module hdr_ratio_encode
  import hdr_ratio_pkg::*;
(
  input  logic       enc,
  input  logic       cmp,
  input  logic       wide,
  output logic [1:0] code
);

  always_comb begin
    if (!enc && !cmp) begin
      code = RATIO_X1;
    end else begin
      code = cmp ? RATIO_X4 : RATIO_X2;
      if (wide) code = code + 2'd1;
    end
  end

endmodule

// File: rtl/hdr_field_capture.sv
module hdr_field_capture #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned ENC_LO  = 2,
  parameter int unsigned ENC_HI  = 3,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned CMP_BIT = 1,
  parameter int unsigned IDX_W   = $clog2(CMP_IDX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              img_start,
  input  logic              accept,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_last,
  input  logic              wide_mode,
  output logic              enc_q,
  output logic              cmp_q,
  output logic [1:0]        code_q,
  output logic              valid_q,
  output logic              err_q
);

  logic       hit_enc, hit_cmp, cmp_now;
  logic [1:0] code_now;

  assign hit_enc = accept && (cur_idx == IDX_W'(ENC_IDX));
  assign hit_cmp = accept && (cur_idx == IDX_W'(CMP_IDX));
  assign cmp_now = ~word_data[CMP_BIT];

  hdr_ratio_encode u_enc (
    .enc  (enc_q),
    .cmp  (cmp_now),
    .wide (wide_mode),
    .code (code_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_q   <= 1'b0;
      cmp_q   <= 1'b0;
      code_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (img_start) begin
        enc_q  <= 1'b0;
        cmp_q  <= 1'b0;
        code_q <= '0;
        err_q  <= 1'b0;
      end
      if (hit_enc) enc_q <= |word_data[ENC_HI:ENC_LO];
      if (hit_cmp) begin
        cmp_q   <= cmp_now;
        code_q  <= code_now;
        valid_q <= 1'b1;
      end
      if (accept && word_last && (cur_idx < IDX_W'(CMP_IDX))) err_q <= 1'b1;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !img_start) |=> err_q);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |-> ($past(img_start) || valid_q));

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned ENC_IDX = DEF_ENC_IDX,
  parameter int unsigned ENC_LO  = DEF_ENC_LO,
  parameter int unsigned ENC_HI  = DEF_ENC_HI,
  parameter int unsigned CMP_IDX = DEF_CMP_IDX,
  parameter int unsigned CMP_BIT = DEF_CMP_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              img_start,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_last,
  input  logic              wide_mode,
  output logic              is_encrypted,
  output logic              is_compressed,
  output logic [1:0]        ratio_code,
  output logic              ratio_valid,
  output logic              short_err
);

  localparam int unsigned IDX_W = $clog2(CMP_IDX + 2);

  logic [IDX_W-1:0] cur_idx;
  logic             accept;

  hdr_word_counter #(
    .LAST_IDX (CMP_IDX),
    .IDX_W    (IDX_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .img_start  (img_start),
    .word_valid (word_valid),
    .cur_idx    (cur_idx),
    .accept     (accept)
  );

  hdr_field_capture #(
    .WORD_W  (WORD_W),
    .ENC_IDX (ENC_IDX),
    .ENC_LO  (ENC_LO),
    .ENC_HI  (ENC_HI),
    .CMP_IDX (CMP_IDX),
    .CMP_BIT (CMP_BIT),
    .IDX_W   (IDX_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .img_start (img_start),
    .accept    (accept),
    .cur_idx   (cur_idx),
    .word_data (word_data),
    .word_last (word_last),
    .wide_mode (wide_mode),
    .enc_q     (is_encrypted),
    .cmp_q     (is_compressed),
    .code_q    (ratio_code),
    .valid_q   (ratio_valid),
    .err_q     (short_err)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (!is_encrypted && !is_compressed && ratio_code == 2'd0 &&
             !ratio_valid && !short_err));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ratio_valid && short_err));

  // R4
  plain_x1_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && !is_encrypted && !is_compressed) |-> ratio_code == 2'd0);

endmodule

// File: tb/hdr_ratio_detect_tb.sv
module hdr_ratio_detect_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       err;
    logic       enc;
    logic       cmp;
    logic [1:0] code;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        img_start = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_last = 1'b0;
  logic        wide_mode = 1'b0;
  logic        is_encrypted, is_compressed, ratio_valid, short_err;
  logic [1:0]  ratio_code;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t sb_q[$];
  logic rv_prev = 1'b0;
  logic err_prev = 1'b0;
  bit   ended = 1'b0;
  int   cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_ratio_detect u_dut (
    .clk           (clk),
    .rst           (rst),
    .img_start     (img_start),
    .word_valid    (word_valid),
    .word_data     (word_data),
    .word_last     (word_last),
    .wide_mode     (wide_mode),
    .is_encrypted  (is_encrypted),
    .is_compressed (is_compressed),
    .ratio_code    (ratio_code),
    .ratio_valid   (ratio_valid),
    .short_err     (short_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input bit e, input bit c, input bit w);
    if (!e && !c) return 2'd0;   // R4
    if (c) return w ? 2'd3 : 2'd2; // R5
    return w ? 2'd2 : 2'd1;
  endfunction

  task automatic beat(input logic s, input logic v, input logic [31:0] d,
                      input logic l);
    @(posedge clk); #1;
    img_start = s; word_valid = v; word_data = d; word_last = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  // Driver: pushes the expected result, then streams the image
  task automatic send_image(input int n, input logic [1:0] epat, input bit cmp,
                            input bit wide, input bit gaps, input bit with_last);
    exp_t e;
    if (n >= 230) begin
      e = '{err: 1'b0, enc: |epat, cmp: cmp, code: exp_code(|epat, cmp, wide)};
      sb_q.push_back(e);
    end else if (with_last) begin
      e = '{err: 1'b1, enc: (n > 69) ? |epat : 1'b0, cmp: 1'b0, code: 2'd0};
      sb_q.push_back(e);
    end
    wide_mode = wide;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = {i[15:0], ~i[15:0]} ^ 32'h5A3C_0000;
      if (i == 69)  d[3:2] = epat;
      if (i == 229) d[1] = ~cmp;
      // R9: idle beat with hostile data that must be ignored
      if (gaps && (i % 7 == 3)) beat(1'b0, 1'b0, ~d, 1'b0);
      beat(i == 0, 1'b1, d, with_last && (i == n - 1));
    end
    idle(3);
  endtask

  // Monitor: pops and compares on each strobe
  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (ratio_valid && short_err)
        chk(1'b0, "R7", "both strobes", 1, 0);
      if (ratio_valid && rv_prev)
        chk(1'b0, "R6", "ratio_valid width", 2, 1);
      if (ratio_valid || (short_err && !err_prev)) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(short_err == e.err && is_encrypted == e.enc &&
              is_compressed == e.cmp && ratio_code == e.code, "R2 R3 R5 R7",
              "result {err,enc,cmp,code}",
              int'({short_err, is_encrypted, is_compressed, ratio_code}),
              int'(e));
        end
      end
      rv_prev  <= ratio_valid;
      err_prev <= short_err;
    end
  end

  task automatic finish_run();
    ended = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      chk(1'b0, "WD", "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    logic [1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!is_encrypted && !is_compressed && ratio_code == 0 && !ratio_valid &&
        !short_err, "R1", "reset outputs",
        int'({is_encrypted, is_compressed, ratio_code, ratio_valid, short_err}), 0);

    send_image(240, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1); // R4 16-bit
    send_image(240, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1); // R4 32-bit
    send_image(235, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1); // R5 enc x2
    send_image(235, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1); // R5 enc x4
    send_image(235, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1); // R5 cmp x4
    send_image(235, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1); // R5 both x8
    send_image(235, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1); // R9 gaps
    send_image(232, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1); // R9 gaps, enc+cmp
    send_image(230, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1); // R7 last on word 229
    send_image(229, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1); // R7 short by one
    send_image(70,  2'b01, 1'b0, 1'b1, 1'b0, 1'b1); // R2 short, enc seen
    send_image(69,  2'b01, 1'b0, 1'b1, 1'b0, 1'b1); // R2 short, enc unseen

    // R8: a start clears short_err and the flags
    beat(1'b1, 1'b0, 32'h0, 1'b0);
    idle(1);
    @(negedge clk);
    chk(!short_err && !is_encrypted && ratio_code == 0, "R8", "cleared by start",
        int'({short_err, is_encrypted, ratio_code}), 0);

    // R8: restart in the middle of an image, only the new image counts
    send_image(100, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    send_image(231, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1);

    // R10: words past 229 leave the result alone
    send_image(230, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
    held = ratio_code;
    for (int i = 0; i < 20; i++)
      beat(1'b0, 1'b1, (i == 0) ? 32'h0 : 32'hFFFF_FFFF, i == 19);
    idle(3);
    @(negedge clk);
    chk(ratio_code == held && ratio_code == 2'd3 && is_compressed && !short_err,
        "R10", "hold after header", int'(ratio_code), 3);

    idle(4);
    @(negedge clk);
    chk(sb_q.size() == 0, "R6", "results left in queue", sb_q.size(), 0);
    finish_run();
  end

endmodule